// File: doc/BRIEF.md
# Ordering-Table Clear Engine

This engine fills a region of RAM with an empty, downward-linked pointer table. It receives a start pulse together with a top word address and a word count. From that address it writes one word per accepted memory cycle, each time moving 4 bytes lower. Every word except the final one holds the byte address of the word just below it. The final word holds a fixed end marker. The result is a chain that software can later splice entries into. The engine always writes into memory and never reads from a device.

The engine drives a single-port write interface with address, data, a write strobe and a ready input. A word counts as accepted on a clock edge where the strobe and ready are both high. All address arithmetic stays inside a RAM of `2**ADDR_W` bytes, so a table that runs past address 0 continues from the top of RAM. Register decode, request gating and interrupt raising belong to the surrounding controller. That controller pulses `start_i` when the channel's trigger bit is set, and it uses `done_o` to end the channel.

Top module: `otc_clear`

## Requirements
- R1: While and after reset, with no start, `mem_we_o` and `done_o` are low.
- R2: A start pulse while idle raises `mem_we_o` on the next cycle. The first address is `base_i` with bits [1:0] cleared and every bit from ADDR_W upward dropped.
- R3: After each accepted word the address falls by 4 and wraps modulo `2**ADDR_W`, so 0 is followed by `2**ADDR_W - 4`.
- R4: Every word except the last carries its own address minus 4, wrapped as in R3 and zero-extended to DATA_W bits.
- R5: The last word carries 0x00FFFFFF. A count of 1 writes that single word at the base address and nothing else.
- R6: A count of 0 writes `2**CNT_W` words (65536 by default).
- R7: One word is accepted on each cycle where `mem_ready_i` is high. While the strobe is high and ready is low, the strobe, address and data stay unchanged.
- R8: `done_o` is high for exactly one cycle, the cycle after the last word is accepted. From that cycle on, `mem_we_o` is low.
- R9: A start pulse while a table is being written is ignored. The running table is neither redirected nor lengthened, and no second table follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle start request |
| base_i | input | BASE_W | Byte address of the first (highest) word |
| count_i | input | CNT_W | Number of words; 0 means 2**CNT_W |
| mem_ready_i | input | 1 | Memory accepts the current write |
| mem_we_o | output | 1 | Write strobe; high for the whole run |
| mem_addr_o | output | ADDR_W | Byte address of the current word |
| mem_wdata_o | output | DATA_W | Word to write |
| done_o | output | 1 | One-cycle pulse after the last accepted word |

## Verification
The tables are run with three ready patterns: always ready, ready on alternate cycles, and ready from a pseudo-random sequence. Matching results across the three show that stalls hold each word without skipping or repeating it. A table of four words shows the basic pointer chain. A table of one word isolates the end-marker path. A table whose base lies just above 0 shows the wrap. An unaligned base with high bits set shows the masking. A zero count shows the full-length expansion. A second start issued mid-run shows that a busy engine does not react to it.

// File: rtl/otc_pkg.sv
package otc_pkg;
  typedef enum logic [0:0] {OTC_IDLE, OTC_RUN} otc_state_e;
  localparam logic [23:0] OTC_END_MARK = 24'hFF_FFFF;
endpackage

// File: rtl/otc_addr_step.sv
// Address register for the descending table plus its pointer arithmetic.
module otc_addr_step #(
  parameter int ADDR_W = 21,
  parameter int BASE_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] base_ptr_o,  // pointer stored in the first word
  output logic [ADDR_W-1:0] next_ptr_o   // pointer stored in the word after the current one
);
  localparam logic [ADDR_W-1:0] AMASK = {{(ADDR_W-2){1'b1}}, 2'b00};
  localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(8);

  logic [ADDR_W-1:0] base_fit;
  logic [ADDR_W-1:0] base_m;
  logic [ADDR_W-1:0] addr_q;

  generate
    if (BASE_W >= ADDR_W) begin : g_trunc
      assign base_fit = base_i[ADDR_W-1:0];
    end else begin : g_ext
      assign base_fit = {{(ADDR_W-BASE_W){1'b0}}, base_i};
    end
  endgenerate

  assign base_m     = base_fit & AMASK;
  assign base_ptr_o = (base_m - STEP1) & AMASK;
  assign next_ptr_o = (addr_q - STEP2) & AMASK;

  always_ff @(posedge clk) begin
    if (rst)         addr_q <= '0;
    else if (load_i) addr_q <= base_m;
    else if (adv_i)  addr_q <= (addr_q - STEP1) & AMASK;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/otc_word_count.sv
// Remaining-word counter; a zero count expands to the full range.
module otc_word_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             adv_i,
  output logic             load_one_o,
  output logic             last_o,
  output logic             two_left_o
);
  localparam int REM_W = CNT_W + 1;
  localparam logic [REM_W-1:0] FULL = {1'b1, {CNT_W{1'b0}}};

  logic [REM_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst)         rem_q <= '0;
    else if (load_i) rem_q <= (count_i == '0) ? FULL : {1'b0, count_i};
    else if (adv_i)  rem_q <= rem_q - REM_W'(1);
  end

  assign load_one_o = (count_i == CNT_W'(1));
  assign last_o     = (rem_q == REM_W'(1));
  assign two_left_o = (rem_q == REM_W'(2));

  // zero count must not be taken as a single-word table
  assert_zero_count_R6: assert property (@(posedge clk) disable iff (rst)
    (load_i && count_i == '0) |=> (!last_o && !two_left_o && rem_q == FULL));
endmodule

// File: rtl/otc_word_fmt.sv
// Forms the word value: a zero-extended pointer or the end marker.
module otc_word_fmt #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 32
) (
  input  logic              is_last_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic [DATA_W-1:0] word_o
);
  import otc_pkg::*;
  logic [DATA_W-1:0] ptr_ext;
  logic [DATA_W-1:0] mark_ext;

  generate
    if (DATA_W > ADDR_W) begin : g_pad
      assign ptr_ext = {{(DATA_W-ADDR_W){1'b0}}, ptr_i};
    end else begin : g_cut
      assign ptr_ext = ptr_i[DATA_W-1:0];
    end
    if (DATA_W > 24) begin : g_mark_pad
      assign mark_ext = {{(DATA_W-24){1'b0}}, OTC_END_MARK};
    end else begin : g_mark_fit
      assign mark_ext = OTC_END_MARK[DATA_W-1:0];
    end
  endgenerate

  assign word_o = is_last_i ? mark_ext : ptr_ext;
endmodule

// File: rtl/otc_clear.sv
module otc_clear #(
  parameter int ADDR_W = 21,
  parameter int BASE_W = 24,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              done_o
);
  import otc_pkg::*;
  localparam logic [ADDR_W-1:0] AMASK = {{(ADDR_W-2){1'b1}}, 2'b00};

  otc_state_e        state_q;
  logic              we_q, done_q;
  logic [DATA_W-1:0] data_q;
  logic              load, accept, adv, finish;
  logic              load_one, last, two_left;
  logic [ADDR_W-1:0] addr, base_ptr, next_ptr, sel_ptr;
  logic              sel_last;
  logic [DATA_W-1:0] word_next;

  assign load   = start_i && (state_q == OTC_IDLE);
  assign accept = we_q && mem_ready_i;
  assign adv    = accept && !last;
  assign finish = accept && last;

  otc_addr_step #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_addr (
    .clk(clk), .rst(rst), .load_i(load), .base_i(base_i), .adv_i(adv),
    .addr_o(addr), .base_ptr_o(base_ptr), .next_ptr_o(next_ptr)
  );

  otc_word_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load_i(load), .count_i(count_i), .adv_i(adv),
    .load_one_o(load_one), .last_o(last), .two_left_o(two_left)
  );

  assign sel_last = load ? load_one : two_left;
  assign sel_ptr  = load ? base_ptr : next_ptr;

  otc_word_fmt #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fmt (
    .is_last_i(sel_last), .ptr_i(sel_ptr), .word_o(word_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= OTC_IDLE;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      done_q <= finish;
      if (load) begin
        state_q <= OTC_RUN;
        we_q    <= 1'b1;
        data_q  <= word_next;
      end else if (finish) begin
        state_q <= OTC_IDLE;
        we_q    <= 1'b0;
      end else if (adv) begin
        data_q  <= word_next;
      end
    end
  end

  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr;
  assign mem_wdata_o = data_q;
  assign done_o      = done_q;

  assert_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> (mem_addr_o[1:0] == 2'b00));

  assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && mem_ready_i) |=> (!mem_we_o || mem_addr_o == (($past(mem_addr_o) - ADDR_W'(4)) & AMASK)));

  assert_ptr_word_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && !last) |-> (mem_wdata_o == DATA_W'((mem_addr_o - ADDR_W'(4)) & AMASK)));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && !mem_ready_i) |=> (mem_we_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(mem_we_o && mem_ready_i) && !mem_we_o));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

// File: tb/tb_otc_clear.sv
module tb_otc_clear;
  localparam int ADDR_W = 10;
  localparam int BASE_W = 24;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 32;
  localparam int MASK   = (1 << ADDR_W) - 4;
  localparam int TERM   = 32'h00FF_FFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [BASE_W-1:0] base = '0;
  logic [CNT_W-1:0]  count = '0;
  logic ready = 1'b1;
  logic we, done;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;

  always #10 clk = ~clk;  // 50 MHz

  otc_clear #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .start_i(start), .base_i(base), .count_i(count),
    .mem_ready_i(ready), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata), .done_o(done)
  );

  int checks = 0;
  int errors = 0;
  int ready_mode = 0;
  int exp_base = 0;
  int exp_n = 0;
  int wr_idx = 0;
  int wr_bad = 0;
  int bad_act_a = 0, bad_exp_a = 0, bad_act_d = 0, bad_exp_d = 0;
  int done_cnt = 0;
  int done_bad = 0;
  bit prev_acc_last = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // ready driver
  initial begin
    forever begin
      @(posedge clk); #1;
      case (ready_mode)
        0: ready = 1'b1;
        1: ready = ~ready;
        default: begin
          lfsr  = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          ready = lfsr[0];
        end
      endcase
    end
  end

  // monitor, sampled mid-cycle
  always @(negedge clk) begin
    bit acc_last;
    int ea, ed;
    acc_last = 1'b0;
    if (!rst) begin
      if (done) begin
        done_cnt++;
        if (!prev_acc_last || we) done_bad++;
      end
      if (we && ready) begin
        ea = (exp_base - 4 * wr_idx) & MASK;
        ed = (wr_idx == exp_n - 1) ? TERM : ((ea - 4) & MASK);
        if (wr_idx >= exp_n || int'(addr) != ea || int'(wdata) != ed) begin
          if (wr_bad == 0) begin
            bad_act_a = int'(addr); bad_exp_a = ea;
            bad_act_d = int'(wdata); bad_exp_d = ed;
          end
          wr_bad++;
        end
        wr_idx++;
        acc_last = (wr_idx == exp_n);
      end
    end
    prev_acc_last = acc_last;
  end

  task automatic run(input string tag, input int b, input int c, input int mode, input bit intrude);
    int n;
    int guard;
    n = (c == 0) ? (1 << CNT_W) : c;
    exp_base = b & MASK;
    exp_n = n; wr_idx = 0; wr_bad = 0; done_cnt = 0; done_bad = 0;
    ready_mode = mode;
    @(posedge clk); #1;
    start = 1'b1; base = BASE_W'(b); count = CNT_W'(c);
    @(posedge clk); #1;
    start = 1'b0;
    if (intrude) begin
      @(posedge clk); #1;
      start = 1'b1; base = BASE_W'(32'h40); count = CNT_W'(2);
      @(posedge clk); #1;
      start = 1'b0;
    end
    guard = 0;
    while (done_cnt == 0 && guard < 4 * n + 50) begin
      @(posedge clk); guard++;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(wr_idx == n, tag, "accepted word count", wr_idx, n);
    check(wr_bad == 0, tag, "word address", bad_act_a, bad_exp_a);
    check(wr_bad == 0, tag, "word data", bad_act_d, bad_exp_d);
    check(done_cnt == 1 && done_bad == 0, tag, "done pulses / misplaced (R8)", done_cnt, 1);
    check(we == 1'b0, tag, "strobe low after done (R8)", int'(we), 0);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(we == 1'b0, "R1", "strobe in reset", int'(we), 0);
    check(done == 1'b0, "R1", "done in reset", int'(done), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(we == 1'b0 && done == 1'b0, "R1", "idle after reset", int'({we, done}), 0);
  endtask

  task automatic test_start_latency();
    // R2: strobe rises the cycle after start, at the masked base
    @(posedge clk); #1;
    exp_base = 32'h1F8; exp_n = 3; wr_idx = 0; wr_bad = 0; done_cnt = 0; done_bad = 0;
    ready_mode = 0;
    start = 1'b1; base = BASE_W'(32'h1F8); count = CNT_W'(3);
    @(negedge clk);
    check(we == 1'b0, "R2", "strobe before start edge", int'(we), 0);
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    check(we == 1'b1 && int'(addr) == 32'h1F8, "R2", "first address", int'(addr), 32'h1F8);
    repeat (6) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    test_reset();
    test_start_latency();
    run("R4", 32'h100, 4, 0, 1'b0);
    run("R5", 32'h80, 1, 0, 1'b0);
    run("R3", 32'h8, 5, 0, 1'b0);
    run("R2", 32'h12345, 6, 0, 1'b0);
    run("R7", 32'h3F0, 9, 1, 1'b0);
    run("R7", 32'h10, 12, 2, 1'b0);
    run("R9", 32'h200, 6, 0, 1'b1);
    run("R6", 32'h200, 0, 0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule